// File: doc/BRIEF.md
# Memory-Type-Aware Ordering Write Buffer

This block sits between a processor's load/store port and a single downstream bus port. Each upstream request carries a two-bit memory type, a write flag, an instruction-fetch flag and an execute-never flag. Writes to Normal and Device memory are posted: they are taken into a small age-ordered queue and acknowledged at once, then issued downstream later. Strongly-ordered writes, all reads and all fetches go straight through. They are acknowledged only in the cycle the downstream port accepts them.

A direct request may overtake buffered writes when no buffered entry orders it. Ordering comes from a pairwise rule on the memory types of the two accesses, plus a same-address rule that keeps single-address coherence. When the direct request is ordered behind a buffered entry, it waits while the queue drains oldest first. A fetch flagged execute-never is never sent downstream. It is acknowledged with a fault flag instead.

Top module: `typed_write_buffer`

## Requirements
- R1: A write with memory type 3 (Strongly-ordered) is never queued. Its upstream acknowledge (`up_valid && up_ready`) happens only in the same cycle as its downstream handshake, which carries the same address, `dn_write=1` and `dn_mtype=3`.
- R2: A write with memory type 0 (Normal), 1 (Device non-shareable) or 2 (Device shareable) is acknowledged while the queue has room, even with `dn_ready` low. It is issued downstream later, oldest queued write first.
- R3: A Strongly-ordered access is never issued ahead of an older queued Device (type 1 or 2) write.
- R4: A Device non-shareable access is never issued ahead of an older queued Device non-shareable write. The same holds for two Device shareable accesses.
- R5: A Device shareable read is issued ahead of older queued Device non-shareable writes to other addresses. The reverse case also holds: a Device non-shareable read overtakes Device shareable writes.
- R6: A Normal read to an address not held in the queue is issued ahead of queued writes of any type.
- R7: A read to an address equal to that of a queued write, of any memory types, is not issued until that write has been issued.
- R8: A fetch (`up_fetch=1`) with `up_xn=1` is acknowledged in the same cycle with `up_fault=1` and never appears downstream. A fetch with `up_xn=0` goes downstream with `dn_fetch=1` and `up_fault=0`.
- R9: With DEPTH (default 4) writes queued, a posted write sees `up_ready=0`. The queue never holds more than DEPTH entries.
- R10: After reset the queue is empty and, with no upstream request, `dn_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted this cycle |
| up_write | input | 1 | 1 = write, 0 = read |
| up_fetch | input | 1 | Request is an instruction fetch (treated as a read) |
| up_xn | input | 1 | Target region forbids instruction execution |
| up_mtype | input | 2 | Memory type: 0 Normal, 1 Device non-shareable, 2 Device shareable, 3 Strongly-ordered |
| up_addr | input | 32 | Request address |
| up_wdata | input | 32 | Write data |
| up_strb | input | 4 | Byte strobes |
| up_fault | output | 1 | Execute-never fetch refused (hard fault) |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream accepts request |
| dn_write | output | 1 | Downstream write flag |
| dn_fetch | output | 1 | Downstream fetch flag |
| dn_mtype | output | 2 | Downstream memory type |
| dn_addr | output | 32 | Downstream address |
| dn_wdata | output | 32 | Downstream write data |
| dn_strb | output | 4 | Downstream byte strobes |

## Verification
The hardest situation to reach is a direct request that arrives while several posted writes are still queued, so that the overtake-or-wait decision is actually exercised. The bench holds `dn_ready` low to fill the queue with writes of chosen types and addresses. It then presents the read, fetch or Strongly-ordered write and inspects the port before releasing the stall. A long phase with pseudo-random types, a small address pool and a random `dn_ready` follows. All downstream handshakes are logged with their upstream order, and every logged pair is checked against the ordering rule.

// File: rtl/owb_pkg.sv
package owb_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;

    typedef enum logic [1:0] {
        MT_NORMAL = 2'd0,
        MT_DEV_NS = 2'd1,
        MT_DEV_SH = 2'd2,
        MT_STRONG = 2'd3
    } mtype_e;

    typedef struct packed {
        logic               is_wr;
        logic               is_fetch;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  data;
        logic [STRB_W-1:0]  strb;
        mtype_e             mt;
    } txn_t;

    // Pairwise type rule: Normal is free against anything, Strongly-ordered
    // is held against every Device/Strong access, Device only against itself.
    function automatic logic types_ordered(mtype_e a, mtype_e b);
        if (a == MT_NORMAL || b == MT_NORMAL) return 1'b0;
        if (a == MT_STRONG || b == MT_STRONG) return 1'b1;
        return (a == b);
    endfunction

    // True when the younger access must not be issued before the older one.
    function automatic logic must_follow(txn_t older, txn_t younger);
        return types_ordered(older.mt, younger.mt) || (older.addr == younger.addr);
    endfunction

endpackage

// File: rtl/owb_queue.sv
module owb_queue
    import owb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  push,
    input  txn_t                  push_txn,
    input  logic                  pop,
    input  logic [IW-1:0]         pop_idx,
    output txn_t [DEPTH-1:0]      slot,
    output logic [DEPTH-1:0]      slot_vld,
    output logic [CW-1:0]         count
);

    txn_t [DEPTH-1:0] nx_slot;
    logic [DEPTH-1:0] nx_vld;
    logic [CW-1:0]    wr_pos;

    // Slots stay compacted: index 0 is the oldest entry.
    always_comb begin
        nx_slot = slot;
        nx_vld  = slot_vld;
        for (int i = 0; i < DEPTH; i++) begin
            if (pop && i >= int'(pop_idx)) begin
                if (i == DEPTH - 1) begin
                    nx_vld[i] = 1'b0;
                end else begin
                    nx_slot[i] = slot[(i == DEPTH - 1) ? i : i + 1];
                    nx_vld[i]  = slot_vld[(i == DEPTH - 1) ? i : i + 1];
                end
            end
        end
        wr_pos = count - CW'(pop);
        if (push) begin
            nx_slot[wr_pos[IW-1:0]] = push_txn;
            nx_vld[wr_pos[IW-1:0]]  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot     <= '0;
            slot_vld <= '0;
            count    <= '0;
        end else begin
            slot     <= nx_slot;
            slot_vld <= nx_vld;
            count    <= count + CW'(push) - CW'(pop);
        end
    end

endmodule

// File: rtl/owb_pick.sv
module owb_pick
    import owb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IW = $clog2(DEPTH)
) (
    input  txn_t [DEPTH-1:0]  slot,
    input  logic [DEPTH-1:0]  slot_vld,
    input  txn_t              in_txn,
    output logic              head_ok,
    output logic [IW-1:0]     head_idx,
    output logic              in_blocked
);

    logic [DEPTH-1:0] free;

    // An entry is issuable when no older valid entry orders it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_free
        logic ok;
        always_comb begin
            ok = slot_vld[g];
            for (int j = 0; j < g; j++) begin
                if (slot_vld[j] && must_follow(slot[j], slot[g])) ok = 1'b0;
            end
        end
        assign free[g] = ok;
    end

    always_comb begin
        head_ok  = 1'b0;
        head_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (free[i]) begin
                head_ok  = 1'b1;
                head_idx = IW'(i);
            end
        end
    end

    always_comb begin
        in_blocked = 1'b0;
        for (int j = 0; j < DEPTH; j++) begin
            if (slot_vld[j] && must_follow(slot[j], in_txn)) in_blocked = 1'b1;
        end
    end

endmodule

// File: rtl/typed_write_buffer.sv
module typed_write_buffer
    import owb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic              up_write,
    input  logic              up_fetch,
    input  logic              up_xn,
    input  logic [1:0]        up_mtype,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [DATA_W-1:0] up_wdata,
    input  logic [STRB_W-1:0] up_strb,
    output logic              up_fault,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic              dn_write,
    output logic              dn_fetch,
    output logic [1:0]        dn_mtype,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    output logic [STRB_W-1:0] dn_strb
);

    txn_t             in_txn;
    txn_t             dn_txn;
    txn_t [DEPTH-1:0] slot;
    logic [DEPTH-1:0] slot_vld;
    logic [CW-1:0]    q_count;
    logic             head_ok;
    logic [IW-1:0]    head_idx;
    logic             in_blocked;
    logic             is_fault, is_direct, is_posted, go_direct, full, q_push, q_pop;

    always_comb begin
        in_txn.is_wr    = up_write & ~up_fetch;
        in_txn.is_fetch = up_fetch;
        in_txn.addr     = up_addr;
        in_txn.data     = up_wdata;
        in_txn.strb     = up_strb;
        in_txn.mt       = mtype_e'(up_mtype);
    end

    assign full      = (q_count == CW'(DEPTH));
    assign is_fault  = up_valid & up_fetch & up_xn;
    assign is_posted = up_valid & in_txn.is_wr & (in_txn.mt != MT_STRONG);
    assign is_direct = up_valid & ~is_fault & ~is_posted;
    assign go_direct = is_direct & ~in_blocked;

    assign q_push = is_posted & ~full;
    assign q_pop  = ~go_direct & head_ok & dn_ready;

    always_comb begin
        if (is_fault)       up_ready = 1'b1;
        else if (is_posted) up_ready = ~full;
        else if (is_direct) up_ready = go_direct & dn_ready;
        else                up_ready = ~full;
    end

    assign up_fault = is_fault;
    assign dn_valid = go_direct | head_ok;
    assign dn_txn   = go_direct ? in_txn : slot[head_idx];
    assign dn_write = dn_txn.is_wr;
    assign dn_fetch = dn_txn.is_fetch;
    assign dn_mtype = dn_txn.mt;
    assign dn_addr  = dn_txn.addr;
    assign dn_wdata = dn_txn.data;
    assign dn_strb  = dn_txn.strb;

    owb_queue #(.DEPTH(DEPTH)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .push     (q_push),
        .push_txn (in_txn),
        .pop      (q_pop),
        .pop_idx  (head_idx),
        .slot     (slot),
        .slot_vld (slot_vld),
        .count    (q_count)
    );

    owb_pick #(.DEPTH(DEPTH)) u_pick (
        .slot       (slot),
        .slot_vld   (slot_vld),
        .in_txn     (in_txn),
        .head_ok    (head_ok),
        .head_idx   (head_idx),
        .in_blocked (in_blocked)
    );

endmodule

// File: rtl/owb_checker.sv
module owb_checker
    import owb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              up_valid,
    input logic              up_ready,
    input logic              up_write,
    input logic              up_fetch,
    input logic              up_xn,
    input logic [1:0]        up_mtype,
    input logic [ADDR_W-1:0] up_addr,
    input logic              up_fault,
    input logic              dn_valid,
    input logic              dn_ready,
    input logic              dn_write,
    input logic              dn_fetch,
    input logic [1:0]        dn_mtype,
    input logic [ADDR_W-1:0] dn_addr,
    input logic [CW-1:0]     count
);

    logic posted_acc, queue_pop;
    assign posted_acc = up_valid && up_ready && up_write && !up_fetch && up_mtype != 2'd3;
    assign queue_pop  = dn_valid && dn_ready && dn_write && dn_mtype != 2'd3;

    assert_strong_ack_R1: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_ready && up_write && !up_fetch && up_mtype == 2'd3)
        |-> (dn_valid && dn_ready && dn_write && dn_mtype == 2'd3 && dn_addr == up_addr));

    assert_posted_grow_R2: assert property (@(posedge clk) disable iff (rst)
        (posted_acc && !queue_pop) |=> (int'(count) == int'($past(count)) + 1));

    assert_xn_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        (up_valid && up_fetch && up_xn) |-> (up_fault && up_ready && !(dn_valid && dn_fetch)));

    assert_fault_needs_req_R8: assert property (@(posedge clk) disable iff (rst)
        up_fault |-> up_valid);

    assert_full_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (int'(count) == DEPTH && up_valid && up_write && !up_fetch && up_mtype != 2'd3)
        |-> !up_ready);

    assert_reset_empty_R10: assert property (@(posedge clk)
        rst |=> (count == '0));

    always @(posedge clk) begin
        if (!rst) begin
            assert_no_overflow_R9: assert (int'(count) <= DEPTH);
        end
    end

endmodule

bind typed_write_buffer owb_checker #(.DEPTH(DEPTH)) u_owb_checker (.*, .count(q_count));

// File: tb/test_typed_write_buffer.sv
module test_typed_write_buffer;
    import owb_pkg::*;

    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        up_valid = 1'b0, up_write = 1'b0, up_fetch = 1'b0, up_xn = 1'b0;
    logic [1:0]  up_mtype = 2'd0;
    logic [31:0] up_addr = '0, up_wdata = '0;
    logic [3:0]  up_strb = 4'hF;
    logic        up_ready, up_fault;
    logic        dn_valid, dn_write, dn_fetch;
    logic        dn_ready = 1'b0;
    logic [1:0]  dn_mtype;
    logic [31:0] dn_addr, dn_wdata;
    logic [3:0]  dn_strb;

    always #4 clk = ~clk;

    typed_write_buffer #(.DEPTH(DEPTH)) i_typed_write_buffer (.*);

    int total = 0, bad = 0;
    bit done = 0;
    int mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit must_wait(int omt, int ymt, int oa, int ya);
        if (oa == ya) return 1;
        if (omt == 0 || ymt == 0) return 0;
        if (omt == 3 || ymt == 3) return 1;
        return omt == ymt;
    endfunction

    // dn_ready driver: 0 held low, 1 held high, 2 pseudo-random
    always @(posedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    always @(posedge clk) begin
        #1;
        if (mode == 2) dn_ready = lfsr[0] | lfsr[3];
        else           dn_ready = (mode == 1);
    end

    // ---------------- behavioural reference model ----------------
    typedef struct { int addr; int mt; int seq; int data; } ment_t;
    ment_t q[$];
    ment_t cap_ent;
    bit    cap_pop, cap_push;
    int    seq_ctr = 0;
    int    lg_seq[$], lg_mt[$], lg_addr[$];

    always @(negedge clk) begin : model_cmp
        bit m_fault, m_direct, m_posted, m_block, m_in, m_valid, m_ready, m_wr;
        int e_addr, e_mt;
        cap_pop  = 0;
        cap_push = 0;
        if (!rst) begin
            m_fault  = up_valid && up_fetch && up_xn;
            m_posted = up_valid && !up_fetch && up_write && up_mtype != 2'd3;
            m_direct = up_valid && !m_fault && !m_posted;
            m_block  = 0;
            foreach (q[k]) if (must_wait(q[k].mt, int'(up_mtype), q[k].addr, int'(up_addr))) m_block = 1;
            m_in    = m_direct && !m_block;
            m_valid = m_in || q.size() > 0;
            chk(dn_valid == m_valid, "R5", "dn_valid", dn_valid, m_valid);
            if (m_valid) begin
                e_addr = m_in ? int'(up_addr) : q[0].addr;
                e_mt   = m_in ? int'(up_mtype) : q[0].mt;
                m_wr   = m_in ? (up_write && !up_fetch) : 1'b1;
                chk(int'(dn_addr) == e_addr, "R5", "dn_addr", dn_addr, e_addr);
                chk(int'(dn_mtype) == e_mt, "R5", "dn_mtype", dn_mtype, e_mt);
                chk(dn_write == m_wr, "R2", "dn_write", dn_write, m_wr);
                if (!m_in) chk(int'(dn_wdata) == q[0].data, "R2", "dn_wdata", dn_wdata, q[0].data);
            end
            if (up_valid) begin
                m_ready = m_fault ? 1'b1 : m_posted ? (q.size() < DEPTH) : (m_in && dn_ready);
                chk(up_ready == m_ready, "R9", "up_ready", up_ready, m_ready);
            end
            chk(up_fault == m_fault, "R8", "up_fault", up_fault, m_fault);
            // R1 monitor: strong write acknowledged only with its bus handshake
            if (up_valid && up_ready && up_write && !up_fetch && up_mtype == 2'd3)
                chk(dn_valid && dn_ready && dn_write && dn_mtype == 2'd3 && dn_addr == up_addr,
                    "R1", "strong write ack without bus completion", dn_valid, 1);
            if (m_valid && dn_ready) begin
                if (m_in) begin
                    lg_seq.push_back(seq_ctr); seq_ctr++;
                    lg_mt.push_back(int'(up_mtype)); lg_addr.push_back(int'(up_addr));
                end else begin
                    lg_seq.push_back(q[0].seq);
                    lg_mt.push_back(q[0].mt); lg_addr.push_back(q[0].addr);
                    cap_pop = 1;
                end
            end
            if (m_posted && q.size() < DEPTH) begin
                cap_ent  = '{addr: int'(up_addr), mt: int'(up_mtype), seq: seq_ctr, data: int'(up_wdata)};
                seq_ctr++;
                cap_push = 1;
            end
        end
    end

    always @(posedge clk) begin
        if (rst) q.delete();
        else begin
            if (cap_pop)  void'(q.pop_front());
            if (cap_push) q.push_back(cap_ent);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic set_rdy(int m);
        mode = m;
        dn_ready = (m == 1);
    endtask

    task automatic put(bit w, bit f, bit x, int mt, int a, int d);
        up_write = w; up_fetch = f; up_xn = x;
        up_mtype = 2'(mt); up_addr = 32'(a); up_wdata = 32'(d);
        up_valid = 1'b1;
    endtask

    task automatic wait_accept();
        do @(negedge clk); while (!up_ready);
        @(posedge clk); #1;
        up_valid = 1'b0;
    endtask

    task automatic send(bit w, bit f, bit x, int mt, int a, int d);
        put(w, f, x, mt, a, d);
        wait_accept();
    endtask

    task automatic drain();
        set_rdy(1);
        repeat (8) @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(dn_valid == 1'b0, "R10", "dn_valid after reset", dn_valid, 0);
        @(posedge clk); #1;

        // R2 and R9: fill the queue while the bus stalls
        set_rdy(0);
        for (int k = 0; k < DEPTH; k++) send(1, 0, 0, 1, 'h100 + 4 * k, 'hA0 + k);
        @(negedge clk);
        chk(dn_valid && dn_write && dn_addr == 32'h100, "R2", "queued head on bus", dn_addr, 'h100);
        @(posedge clk); #1;
        put(1, 0, 0, 1, 'h110, 'hA4);
        repeat (3) begin
            @(negedge clk);
            chk(!up_ready, "R9", "posted write stalls when full", up_ready, 0);
        end
        @(posedge clk); #1 up_valid = 1'b0;

        // R5: shareable read overtakes non-shareable writes
        put(0, 0, 0, 2, 'h200, 0);
        @(negedge clk);
        chk(dn_valid && !dn_write && dn_addr == 32'h200, "R5", "read overtakes", dn_addr, 'h200);
        @(posedge clk); #1 set_rdy(1);
        wait_accept();
        drain();

        // R3: strong read waits behind a device write
        set_rdy(0);
        send(1, 0, 0, 2, 'h300, 'h33);
        put(0, 0, 0, 3, 'h400, 0);
        @(negedge clk);
        chk(dn_addr == 32'h300 && !up_ready, "R3", "strong read held", dn_addr, 'h300);
        @(posedge clk); #1 set_rdy(1);
        wait_accept();
        drain();

        // R4: same-type device order
        set_rdy(0);
        send(1, 0, 0, 1, 'h800, 'h80);
        send(1, 0, 0, 1, 'h804, 'h84);
        put(0, 0, 0, 1, 'h900, 0);
        @(negedge clk);
        chk(dn_addr == 32'h800 && !up_ready, "R4", "device ns read held", dn_addr, 'h800);
        @(posedge clk); #1 set_rdy(1);
        wait_accept();
        drain();

        // R7: same-address read waits
        set_rdy(0);
        send(1, 0, 0, 0, 'h500, 'h55);
        put(0, 0, 0, 0, 'h500, 0);
        @(negedge clk);
        chk(dn_write && dn_addr == 32'h500 && !up_ready, "R7", "same address read held", dn_write, 1);
        @(posedge clk); #1 set_rdy(1);
        wait_accept();
        drain();

        // R6: normal read overtakes any type
        set_rdy(0);
        send(1, 0, 0, 1, 'h600, 'h66);
        send(1, 0, 0, 2, 'h604, 'h67);
        put(0, 0, 0, 0, 'h700, 0);
        @(negedge clk);
        chk(!dn_write && dn_addr == 32'h700, "R6", "normal read overtakes", dn_addr, 'h700);
        @(posedge clk); #1 set_rdy(1);
        wait_accept();
        drain();

        // R8: execute-never fetch
        set_rdy(0);
        put(0, 1, 1, 0, 'hB00, 0);
        @(negedge clk);
        chk(up_fault && up_ready && !dn_valid, "R8", "xn fetch refused", dn_valid, 0);
        @(posedge clk); #1 up_valid = 1'b0;
        put(0, 1, 0, 0, 'hB04, 0);
        @(negedge clk);
        chk(!up_fault && dn_valid && dn_fetch, "R8", "plain fetch issued", dn_fetch, 1);
        @(posedge clk); #1 set_rdy(1);
        wait_accept();
        drain();

        // R1: strong write not acknowledged while bus stalls
        set_rdy(0);
        put(1, 0, 0, 3, 'hA00, 'hAA);
        repeat (2) begin
            @(negedge clk);
            chk(!up_ready && dn_valid && dn_write, "R1", "strong write held", up_ready, 0);
        end
        @(posedge clk); #1 set_rdy(1);
        wait_accept();
        drain();

        // mixed traffic with random bus stalls
        set_rdy(2);
        for (int n = 0; n < 400; n++) begin
            bit f, w, x;
            f = ($urandom_range(0, 7) == 0);
            w = f ? 1'b0 : 1'($urandom_range(0, 1));
            x = f ? 1'($urandom_range(0, 1)) : 1'b0;
            send(w, f, x, $urandom_range(0, 3), 'h1000 + 4 * $urandom_range(0, 7), $urandom);
            if ($urandom_range(0, 3) == 0) begin
                @(posedge clk); #1;
            end
        end
        drain();

        // R3 R4: pairwise order of every bus handshake
        for (int i = 0; i < lg_seq.size(); i++) begin
            for (int j = i + 1; j < lg_seq.size(); j++) begin
                bit inv;
                inv = (lg_seq[j] < lg_seq[i]) && must_wait(lg_mt[j], lg_mt[i], lg_addr[j], lg_addr[i]);
                chk(!inv, "R3 R4", "ordered pair reversed", lg_seq[i], lg_seq[j]);
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule